// File: doc/BRIEF.md
# Oversampled SPI Bus Monitor

The block watches an SPI bus without driving any of its lines. All four bus signals (serial clock, controller-to-peripheral data, peripheral-to-controller data and select) are sampled by a fast system clock. The sampled lines are resynchronised, and the active serial-clock edge is found by comparing consecutive samples. Bits of both data lines are shifted in on that edge, and one record is produced per completed byte. A record holds the byte seen on each data line and the value of a free-running cycle counter.

Clock polarity, clock phase, bit order and select polarity are set at run time from configuration inputs. A trigger unit decides when records start to leave the block. It can fire immediately, on select becoming active, on select becoming inactive, or on a chosen byte value on the controller-to-peripheral line. Until it fires, a small ring keeps the most recent records. When it fires, those records are emitted first, oldest first, and live records follow.

The system clock must run at least four times the serial clock rate. Eight to ten times is the intended operating point.

Top module: `spimon_top`

## Requirements
- R1: The sampling edge follows the mode. With cfg_cpol=0 the serial clock idles low, with cfg_cpol=1 it idles high. With cfg_cpha=0 bits are taken on the first edge leaving idle, with cfg_cpha=1 on the edge returning to idle. Bytes are decoded correctly in all four combinations.
- R2: With cfg_lsb_first=0 the first bit of a byte is its most significant bit. With cfg_lsb_first=1 it is the least significant bit.
- R3: Select is active when spi_cs equals cfg_sel_high. Serial-clock edges while select is inactive produce no record.
- R4: Both data lines are decoded in parallel, giving one record per eight bits, with rec_mosi and rec_miso from the same byte slot.
- R5: If select goes inactive after 1 to 7 bits of a byte, the partial byte is discarded, frag_err pulses for exactly one cycle, and the next frame's first byte is decoded from its first bit.
- R6: rec_time is the cycle count at which the byte's last bit was taken. The difference between two records' times equals the number of system cycles between their last sampled edges.
- R7: No record is emitted before the trigger fires. triggered stays high once set, until reset.
- R8: Trigger mode 1 fires when select becomes active, and mode 2 fires when select becomes inactive. Bus idling after reset fires neither.
- R9: Trigger mode 3 fires on the record whose controller-to-peripheral byte equals cfg_pattern.
- R10: On firing, the last HIST_DEPTH records are emitted in arrival order, including a record that caused the trigger. Every later record follows in order.
- R11: Trigger mode 0 fires at once after reset, so every record is emitted.
- R12: After reset rec_valid, frag_err and triggered are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| spi_sclk | input | 1 | Observed serial clock |
| spi_mosi | input | 1 | Observed controller-to-peripheral data |
| spi_miso | input | 1 | Observed peripheral-to-controller data |
| spi_cs | input | 1 | Observed select line |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: on trailing edge |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_sel_high | input | 1 | 1: select is active high |
| cfg_trig_mode | input | 2 | 0 immediate, 1 select on, 2 select off, 3 byte match |
| cfg_pattern | input | 8 | Byte value for trigger mode 3 |
| rec_valid | output | 1 | Record strobe |
| rec_mosi | output | 8 | Controller-to-peripheral byte |
| rec_miso | output | 8 | Peripheral-to-controller byte |
| rec_time | output | TS_W | Cycle stamp of the byte's last bit |
| frag_err | output | 1 | One-cycle pulse when a partial byte is dropped |
| triggered | output | 1 | Trigger has fired |

## Verification
The hardest case to reach is the pre-trigger ring wrapping. Before the trigger fires, the ring has to overwrite older records, and then it has to drain while live bytes keep arriving. Three stimulus paths get there:
- Frames longer than the ring are sent before a select-release trigger.
- A matching byte is sent after more than HIST_DEPTH earlier bytes.
- Partial bytes are cut off by an early select release, which shows whether the bit counter re-aligns.

Random byte values and all sixteen combinations of mode, bit order and select polarity are mixed with these directed frames.

// File: rtl/spimon_pkg.sv
// Shared types for the SPI bus monitor.
package spimon_pkg;
    typedef enum logic [1:0] {
        TRIG_NOW     = 2'd0,
        TRIG_SEL_ON  = 2'd1,
        TRIG_SEL_OFF = 2'd2,
        TRIG_MATCH   = 2'd3
    } trig_mode_e;

    typedef struct packed {
        logic [7:0] mosi;
        logic [7:0] miso;
    } byte_pair_t;
endpackage

// File: rtl/spimon_sync.sv
// Two-flop synchroniser for a bundle of asynchronous lines.
// Assumes each line is an independent level; no bus coherence is implied.
module spimon_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stage1;

    // Two register stages per line to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            d_out  <= '0;
        end else begin
            stage1 <= d_in;
            d_out  <= stage1;
        end
    end
endmodule

// File: rtl/spimon_deser.sv
// Edge detection and byte assembly for both data lines.
// Assumes synchronised inputs and configuration that is stable during a frame.
// Edge and select events are suppressed for three cycles after reset,
// until the synchroniser holds real line values.
module spimon_deser
    import spimon_pkg::*;
#(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_s,
    input  logic            mosi_s,
    input  logic            miso_s,
    input  logic            cs_s,
    input  logic            cpol,
    input  logic            cpha,
    input  logic            lsb_first,
    input  logic            sel_high,
    output logic            rec_v,
    output byte_pair_t      rec,
    output logic [TS_W-1:0] rec_ts,
    output logic            sel_on_evt,
    output logic            sel_off_evt,
    output logic            frag_err,
    output logic            sel_act
);
    logic [1:0]      warm_cnt;
    logic            warm;
    logic            sclk_q, sel_q;
    logic            rise, fall, samp;
    logic [2:0]      bit_cnt;
    logic [7:0]      sh_mo, sh_mi, nxt_mo, nxt_mi;
    logic [TS_W-1:0] ts;

    assign warm    = (warm_cnt == 2'd3);
    assign sel_act = sel_high ? cs_s : ~cs_s;
    assign rise    = sclk_s & ~sclk_q;
    assign fall    = ~sclk_s & sclk_q;
    // Modes 1 and 2 sample on the falling edge, modes 0 and 3 on the rising edge.
    assign samp    = ((cpol ^ cpha) ? fall : rise) & sel_act & warm;
    assign nxt_mo  = lsb_first ? {mosi_s, sh_mo[7:1]} : {sh_mo[6:0], mosi_s};
    assign nxt_mi  = lsb_first ? {miso_s, sh_mi[7:1]} : {sh_mi[6:0], miso_s};

    // Warm-up counter and previous-value registers for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_cnt <= 2'd0;
            sclk_q   <= 1'b0;
            sel_q    <= 1'b0;
            ts       <= '0;
        end else begin
            if (!warm) warm_cnt <= warm_cnt + 2'd1;
            sclk_q <= sclk_s;
            sel_q  <= sel_act;
            ts     <= ts + 1'b1;
        end
    end

    // Bit counter and shift registers; cleared whenever select is inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= 3'd0;
            sh_mo   <= 8'd0;
            sh_mi   <= 8'd0;
        end else if (!sel_act) begin
            bit_cnt <= 3'd0;
        end else if (samp) begin
            bit_cnt <= bit_cnt + 3'd1;
            sh_mo   <= nxt_mo;
            sh_mi   <= nxt_mi;
        end
    end

    // Record and event pulses, registered once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_v       <= 1'b0;
            rec         <= '0;
            rec_ts      <= '0;
            sel_on_evt  <= 1'b0;
            sel_off_evt <= 1'b0;
            frag_err    <= 1'b0;
        end else begin
            rec_v       <= samp && (bit_cnt == 3'd7);
            if (samp && (bit_cnt == 3'd7)) begin
                rec.mosi <= nxt_mo;
                rec.miso <= nxt_mi;
                rec_ts   <= ts;
            end
            sel_on_evt  <= warm & sel_act & ~sel_q;
            sel_off_evt <= warm & ~sel_act & sel_q;
            frag_err    <= warm & ~sel_act & sel_q & (bit_cnt != 3'd0);
        end
    end
endmodule

// File: rtl/spimon_trig.sv
// Trigger decision and pre-trigger history ring.
// Before the trigger fires, the ring keeps the newest DEPTH records and overwrites the oldest.
// After it fires, the ring drains one record per cycle.
// Assumes records arrive far less often than once per cycle, so the ring never overflows while draining.
module spimon_trig
    import spimon_pkg::*;
#(
    parameter int TS_W  = 32,
    parameter int DEPTH = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [1:0]                     mode,
    input  logic [7:0]                     pattern,
    input  logic                           in_v,
    input  byte_pair_t                     in_rec,
    input  logic [TS_W-1:0]                in_ts,
    input  logic                           sel_on_evt,
    input  logic                           sel_off_evt,
    output logic                           out_v,
    output byte_pair_t                     out_rec,
    output logic [TS_W-1:0]                out_ts,
    output logic                           triggered,
    output logic [$clog2(DEPTH+1)-1:0]     hist_cnt
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    byte_pair_t      pair_mem [DEPTH];
    logic [TS_W-1:0] ts_mem   [DEPTH];
    logic [PW-1:0]   wr_ptr, rd_ptr;
    logic            fire, pop, drop;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Trigger condition selected by mode.
    always_comb begin
        case (trig_mode_e'(mode))
            TRIG_NOW:     fire = 1'b1;
            TRIG_SEL_ON:  fire = sel_on_evt;
            TRIG_SEL_OFF: fire = sel_off_evt;
            default:      fire = in_v && (in_rec.mosi == pattern);
        endcase
    end

    assign pop  = triggered && (hist_cnt != '0);
    assign drop = !triggered && in_v && (hist_cnt == CW'(DEPTH));

    // Sticky trigger flag.
    always_ff @(posedge clk) begin
        if (!rst_n) triggered <= 1'b0;
        else        triggered <= triggered | fire;
    end

    // Ring storage writes.
    always_ff @(posedge clk) begin
        if (in_v) begin
            pair_mem[wr_ptr] <= in_rec;
            ts_mem[wr_ptr]   <= in_ts;
        end
    end

    // Ring pointers, occupancy and registered output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            hist_cnt <= '0;
            out_v    <= 1'b0;
            out_rec  <= '0;
            out_ts   <= '0;
        end else begin
            if (in_v) wr_ptr <= ptr_next(wr_ptr);
            if (pop || drop) rd_ptr <= ptr_next(rd_ptr);
            hist_cnt <= hist_cnt + CW'(in_v) - CW'(pop || drop);
            out_v <= pop;
            if (pop) begin
                out_rec <= pair_mem[rd_ptr];
                out_ts  <= ts_mem[rd_ptr];
            end
        end
    end
endmodule

// File: rtl/spimon_top.sv
// Passive SPI bus monitor: synchronise, decode, trigger, emit records.
// Assumes the system clock runs at least four times the serial clock rate.
module spimon_top
    import spimon_pkg::*;
#(
    parameter int TS_W       = 32,
    parameter int HIST_DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            spi_sclk,
    input  logic            spi_mosi,
    input  logic            spi_miso,
    input  logic            spi_cs,
    input  logic            cfg_cpol,
    input  logic            cfg_cpha,
    input  logic            cfg_lsb_first,
    input  logic            cfg_sel_high,
    input  logic [1:0]      cfg_trig_mode,
    input  logic [7:0]      cfg_pattern,
    output logic            rec_valid,
    output logic [7:0]      rec_mosi,
    output logic [7:0]      rec_miso,
    output logic [TS_W-1:0] rec_time,
    output logic            frag_err,
    output logic            triggered
);
    localparam int CW = $clog2(HIST_DEPTH + 1);

    logic [3:0]      lines_s;
    logic            dec_v, sel_on_evt, sel_off_evt, sel_active;
    byte_pair_t      dec_rec, out_rec;
    logic [TS_W-1:0] dec_ts;
    logic [CW-1:0]   hist_cnt;

    spimon_sync #(.W(4)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({spi_cs, spi_miso, spi_mosi, spi_sclk}),
        .d_out (lines_s)
    );

    spimon_deser #(.TS_W(TS_W)) u_deser (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_s      (lines_s[0]),
        .mosi_s      (lines_s[1]),
        .miso_s      (lines_s[2]),
        .cs_s        (lines_s[3]),
        .cpol        (cfg_cpol),
        .cpha        (cfg_cpha),
        .lsb_first   (cfg_lsb_first),
        .sel_high    (cfg_sel_high),
        .rec_v       (dec_v),
        .rec         (dec_rec),
        .rec_ts      (dec_ts),
        .sel_on_evt  (sel_on_evt),
        .sel_off_evt (sel_off_evt),
        .frag_err    (frag_err),
        .sel_act     (sel_active)
    );

    spimon_trig #(.TS_W(TS_W), .DEPTH(HIST_DEPTH)) u_trig (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (cfg_trig_mode),
        .pattern     (cfg_pattern),
        .in_v        (dec_v),
        .in_rec      (dec_rec),
        .in_ts       (dec_ts),
        .sel_on_evt  (sel_on_evt),
        .sel_off_evt (sel_off_evt),
        .out_v       (rec_valid),
        .out_rec     (out_rec),
        .out_ts      (rec_time),
        .triggered   (triggered),
        .hist_cnt    (hist_cnt)
    );

    assign rec_mosi = out_rec.mosi;
    assign rec_miso = out_rec.miso;
endmodule

// File: rtl/spimon_chk.sv
// Property checker for the SPI bus monitor, bound to the top module.
module spimon_chk #(
    parameter int TS_W  = 32,
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       rec_valid,
    input logic [TS_W-1:0]            rec_time,
    input logic                       frag_err,
    input logic                       triggered,
    input logic                       sel_active,
    input logic [$clog2(DEPTH+1)-1:0] hist_cnt
);
    logic            seen_q;
    logic [TS_W-1:0] last_ts;

    // Remember the stamp of the previous emitted record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            last_ts <= '0;
        end else if (rec_valid) begin
            seen_q  <= 1'b1;
            last_ts <= rec_time;
        end
    end

    AST_OUT_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> triggered); // R7
    AST_TRIG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        triggered |=> triggered); // R7
    AST_FRAG_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        frag_err |-> (!$past(sel_active) && $past(sel_active, 2))); // R5
    AST_FRAG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frag_err |=> !frag_err); // R5
    AST_HIST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        hist_cnt <= ($clog2(DEPTH+1))'(DEPTH)); // R10
    AST_TIME_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && seen_q) |-> (rec_time > last_ts)); // R6
endmodule

bind spimon_top spimon_chk #(.TS_W(TS_W), .DEPTH(HIST_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rec_valid  (rec_valid),
    .rec_time   (rec_time),
    .frag_err   (frag_err),
    .triggered  (triggered),
    .sel_active (sel_active),
    .hist_cnt   (hist_cnt)
);

// File: tb/spimon_top_tb_top.sv
module spimon_top_tb_top;
    localparam int TS_W = 32;
    localparam int DEPTH = 4;
    localparam int H = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, mosi = 1'b0, miso = 1'b0, cs = 1'b1;
    logic cpol = 1'b0, cpha = 1'b0, lsb = 1'b0, selh = 1'b0;
    logic [1:0] tmode = 2'd0;
    logic [7:0] pat = 8'h00;
    logic rec_valid, frag_err, triggered;
    logic [7:0] rec_mosi, rec_miso;
    logic [TS_W-1:0] rec_time;

    int checks = 0, errors = 0, cyc = 0, frag_n = 0;
    bit done = 1'b0;
    logic [7:0] tx_mo [16];
    logic [7:0] tx_mi [16];
    logic [7:0] sent_mo [$];
    logic [7:0] sent_mi [$];
    int sent_cyc [$];
    logic [7:0] got_mo [$];
    logic [7:0] got_mi [$];
    logic [TS_W-1:0] got_ts [$];

    always #2.5 clk = ~clk;

    spimon_top #(.TS_W(TS_W), .HIST_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso), .spi_cs(cs),
        .cfg_cpol(cpol), .cfg_cpha(cpha), .cfg_lsb_first(lsb), .cfg_sel_high(selh),
        .cfg_trig_mode(tmode), .cfg_pattern(pat),
        .rec_valid(rec_valid), .rec_mosi(rec_mosi), .rec_miso(rec_miso),
        .rec_time(rec_time), .frag_err(frag_err), .triggered(triggered)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Collect emitted records and error pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rec_valid) begin
                got_mo.push_back(rec_mosi);
                got_mi.push_back(rec_miso);
                got_ts.push_back(rec_time);
            end
            if (frag_err) frag_n = frag_n + 1;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic wait_h();
        repeat (H) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sclk = cpol;
        cs = ~selh;
        repeat (3) @(negedge clk);
        sent_mo.delete(); sent_mi.delete(); sent_cyc.delete();
        got_mo.delete(); got_mi.delete(); got_ts.delete();
        frag_n = 0;
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // One frame of n bytes from tx arrays; the last byte carries last_bits bits.
    task automatic send_frame(input int n, input int last_bits);
        cs = selh;
        wait_h();
        for (int b = 0; b < n; b++) begin
            int nb;
            int c_last;
            nb = (b == n - 1) ? last_bits : 8;
            c_last = 0;
            for (int i = 0; i < nb; i++) begin
                int idx;
                idx = lsb ? i : 7 - i;
                if (!cpha) begin
                    mosi = tx_mo[b][idx]; miso = tx_mi[b][idx];
                    wait_h();
                    sclk = ~cpol; c_last = cyc;
                    wait_h();
                    sclk = cpol;
                end else begin
                    sclk = ~cpol;
                    mosi = tx_mo[b][idx]; miso = tx_mi[b][idx];
                    wait_h();
                    sclk = cpol; c_last = cyc;
                    wait_h();
                end
            end
            if (nb == 8) begin
                sent_mo.push_back(tx_mo[b]);
                sent_mi.push_back(tx_mi[b]);
                sent_cyc.push_back(c_last);
            end
        end
        wait_h();
        cs = ~selh;
        wait_h(); wait_h();
    endtask

    task automatic fill_random(input int n);
        for (int b = 0; b < n; b++) begin
            tx_mo[b] = 8'($urandom);
            tx_mi[b] = 8'($urandom);
        end
    endtask

    // Compare emitted records with sent bytes from index start onward.
    task automatic check_records(input int start, input string tag);
        int n_exp, n;
        repeat (30) @(negedge clk);
        n_exp = sent_mo.size() - start;
        check(got_mo.size() == n_exp, {tag, " record count"}, got_mo.size(), n_exp);
        n = (got_mo.size() < n_exp) ? got_mo.size() : n_exp;
        for (int i = 0; i < n; i++) begin
            check(got_mo[i] == sent_mo[start + i], {tag, " mosi byte"}, got_mo[i], sent_mo[start + i]);
            check(got_mi[i] == sent_mi[start + i], {tag, " miso byte"}, got_mi[i], sent_mi[start + i]);
            // R6: stamp spacing equals spacing of last sampled edges
            check(int'(got_ts[i] - got_ts[0]) == sent_cyc[start + i] - sent_cyc[start],
                  "R6 time delta", int'(got_ts[i] - got_ts[0]), sent_cyc[start + i] - sent_cyc[start]);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed1234));
        // R12: reset state
        do_reset();
        check(rec_valid == 1'b0, "R12 rec_valid after reset", rec_valid, 0);
        check(frag_err == 1'b0, "R12 frag_err after reset", frag_err, 0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(triggered == 1'b0, "R12 triggered in reset", triggered, 0);

        // R1 R2 R3 R4 R11: every mode, bit order and select polarity, immediate trigger
        for (int m = 0; m < 16; m++) begin
            cpol = m[0]; cpha = m[1]; lsb = m[2]; selh = m[3];
            tmode = 2'd0;
            do_reset();
            check(triggered == 1'b1, "R11 immediate trigger", triggered, 1);
            fill_random(3);
            send_frame(3, 8);
            fill_random(2);
            tx_mo[0] = 8'h80; tx_mi[0] = 8'h01;
            send_frame(2, 8);
            check_records(0, "R1 R2 R3 R4 decode");
        end

        // R3: clocking with select inactive produces nothing
        cpol = 0; cpha = 0; lsb = 0; selh = 0; tmode = 2'd0;
        do_reset();
        mosi = 1'b1; miso = 1'b1;
        for (int i = 0; i < 16; i++) begin
            wait_h(); sclk = 1'b1; wait_h(); sclk = 1'b0;
        end
        repeat (20) @(negedge clk);
        check(got_mo.size() == 0, "R3 no record with select inactive", got_mo.size(), 0);

        // R5: partial byte dropped, error pulse, next frame aligned
        fill_random(2);
        send_frame(2, 5);
        repeat (10) @(negedge clk);
        check(frag_n == 1, "R5 frag_err pulses once", frag_n, 1);
        fill_random(1);
        send_frame(1, 8);
        check_records(0, "R5 realign after drop");
        fill_random(1);
        send_frame(1, 3);
        repeat (10) @(negedge clk);
        check(frag_n == 2, "R5 second drop", frag_n, 2);

        // R9 R10 R7: byte-match trigger with history wrap
        cpol = 1; cpha = 1; lsb = 0; selh = 0; tmode = 2'd3; pat = 8'hA5;
        do_reset();
        for (int b = 0; b < 5; b++) begin
            do tx_mo[b] = 8'($urandom); while (tx_mo[b] == 8'hA5);
            tx_mi[b] = 8'($urandom);
        end
        send_frame(5, 8);
        repeat (20) @(negedge clk);
        check(triggered == 1'b0, "R7 not triggered before match", triggered, 0);
        check(got_mo.size() == 0, "R7 nothing emitted before trigger", got_mo.size(), 0);
        tx_mo[0] = 8'hA5; tx_mi[0] = 8'($urandom);
        tx_mo[1] = 8'h3C; tx_mi[1] = 8'($urandom);
        send_frame(2, 8);
        check(triggered == 1'b1, "R9 match trigger fired", triggered, 1);
        check_records(5 - DEPTH + 1, "R9 R10 match history");

        // R8 R10: select-release trigger after a long frame
        cpol = 1; cpha = 0; lsb = 1; selh = 1; tmode = 2'd2;
        do_reset();
        repeat (20) @(negedge clk);
        check(triggered == 1'b0, "R8 no trigger from idle", triggered, 0);
        fill_random(6);
        send_frame(6, 8);
        fill_random(2);
        send_frame(2, 8);
        check_records(6 - DEPTH, "R8 R10 release history");

        // R8: select-on trigger, empty history
        cpol = 0; cpha = 1; lsb = 0; selh = 0; tmode = 2'd1;
        do_reset();
        repeat (20) @(negedge clk);
        check(triggered == 1'b0, "R8 no trigger before select", triggered, 0);
        fill_random(3);
        send_frame(3, 8);
        check_records(0, "R8 select-on trigger");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule